// File: doc/BRIEF.md
# Interrupt Acknowledge Bus Sequencer

This block turns a maskable interrupt request into the bus traffic that fetches the interrupt vector. The request line may arrive asynchronously, so it is resynchronized and qualified first. A qualified request then waits for the core's instruction-boundary strobe before the block claims the bus.

Once started, the block runs two read cycles as one locked operation. All control indicators are low and the address is zero in both cycles, and each cycle has its own fixed byte-enable pattern. The data returned in the first cycle is discarded. The low byte returned in the second cycle is the interrupt vector, and it is presented with a one-clock valid pulse. After the final ready, lock stays low for a programmable number of clocks before another locked sequence can begin. This gives other masters a window to arbitrate.

Top module: `intack_seq`

## Requirements
- R1: `irq_in` passes through two flops. A request is qualified only when the synchronized level is high on two consecutive clocks. A high level lasting a single clock never starts a sequence. With `irq_in` and `insn_bdry` both held high from one clock edge onward, out of idle, `ads` is high in the fifth cycle after that edge.
- R2: A qualified request waits for `insn_bdry`. `ads` rises in the cycle after `insn_bdry` is sampled high. If the synchronized request falls while waiting, the request is dropped and a later boundary strobe starts nothing.
- R3: Each of the two acknowledge cycles has a one-clock `ads` followed by a data phase. The data phase ends on the first `rdy` sampled high within it. `rdy` sampled during an `ads` cycle, or while no sequence runs, is ignored.
- R4: While `lock` is high, `dc`, `mio` and `wr` are 0 and `addr` is all zeros. While idle, `dc`, `mio` and `wr` sit at 1 and `be_n` is all ones.
- R5: `be_n` is active low. It is all ones except bit 4 (EFh for 8 lanes) through the whole first cycle. It is all ones except bit 0 (FEh) through the whole second cycle.
- R6: `lock` rises in the same cycle as the first `ads`. It stays high through both cycles and is low in the cycle after the second cycle's `rdy` is sampled.
- R7: The second cycle's `rdy` loads `rdata` into `vec`. `vec_vld` is high for exactly one clock, in the cycle where `lock` first reads low. The first cycle's `rdata` leaves `vec` unchanged.
- R8: After a sequence ends, `lock` stays low for at least `GAP_CLKS` clocks. With request and boundary held high, the next `ads` follows after exactly `GAP_CLKS`+2 clocks of low `lock`.
- R9: After reset, `ads`, `lock`, `vec_vld` and `vec` are 0, `dc`, `mio` and `wr` are 1, and `be_n` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 1 | Maskable interrupt request, may be asynchronous |
| insn_bdry | input | 1 | Instruction boundary strobe from the core |
| rdy | input | 1 | Bus ready, ends a data phase |
| rdata | input | VEC_W | Low byte of the read data bus |
| ads | output | 1 | Address strobe, one clock per cycle |
| lock | output | 1 | Bus lock spanning both cycles |
| dc | output | 1 | Data/control indicator |
| mio | output | 1 | Memory/IO indicator |
| wr | output | 1 | Write/read indicator |
| be_n | output | BE_W | Active-low byte enables |
| addr | output | ADDR_W | Cycle address |
| vec | output | VEC_W | Captured interrupt vector |
| vec_vld | output | 1 | One-clock pulse when `vec` is loaded |

## Verification
The bench builds the block with `GAP_CLKS` = 3 and default widths (eight byte lanes, eight-bit vector). A three-clock gap separates the programmed lock-off time from the two fixed idle and wait cycles, so a back-to-back run measures a five-cycle lock-low window that only comes out right when the gap counter is honoured. The table of runs varies the wait states in each data phase, the returned vector, and the presence of a ready during the strobe cycle. This exercises both byte-enable patterns and the ignored-ready paths.

// File: rtl/intack_seq.sv
module intack_seq #(
  parameter int ADDR_W   = 29,
  parameter int BE_W     = 8,
  parameter int VEC_W    = 8,
  parameter int GAP_CLKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_in,
  input  logic              insn_bdry,
  input  logic              rdy,
  input  logic [VEC_W-1:0]  rdata,
  output logic              ads,
  output logic              lock,
  output logic              dc,
  output logic              mio,
  output logic              wr,
  output logic [BE_W-1:0]   be_n,
  output logic [ADDR_W-1:0] addr,
  output logic [VEC_W-1:0]  vec,
  output logic              vec_vld
);

  localparam int GW = (GAP_CLKS < 2) ? 1 : $clog2(GAP_CLKS);
  localparam logic [BE_W-1:0] BE_FIRST  = ~(BE_W'(1) << 4);
  localparam logic [BE_W-1:0] BE_SECOND = ~(BE_W'(1));
  localparam logic [GW-1:0]   GAP_LAST  = GW'(GAP_CLKS - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_A1, S_D1, S_A2, S_D2, S_GAP
  } st_t;

  st_t           st;
  logic          sync_a, sync_b, sync_c;
  logic [GW-1:0] gap_cnt;
  logic          qual;

  assign qual = sync_b & sync_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      sync_c <= 1'b0;
    end else begin
      sync_a <= irq_in;
      sync_b <= sync_a;
      sync_c <= sync_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      gap_cnt <= '0;
      vec     <= '0;
      vec_vld <= 1'b0;
    end else begin
      vec_vld <= 1'b0;
      case (st)
        S_IDLE: if (qual) st <= S_WAIT;
        S_WAIT: begin
          if (!sync_b)        st <= S_IDLE;
          else if (insn_bdry) st <= S_A1;
        end
        S_A1: st <= S_D1;
        S_D1: if (rdy) st <= S_A2;
        S_A2: st <= S_D2;
        S_D2: if (rdy) begin
          st      <= S_GAP;
          gap_cnt <= '0;
          vec     <= rdata;
          vec_vld <= 1'b1;
        end
        S_GAP: begin
          if (gap_cnt == GAP_LAST) st <= S_IDLE;
          else gap_cnt <= gap_cnt + GW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic in_c1, in_c2;
  assign in_c1 = (st == S_A1) || (st == S_D1);
  assign in_c2 = (st == S_A2) || (st == S_D2);

  assign ads  = (st == S_A1) || (st == S_A2);
  assign lock = in_c1 || in_c2;
  assign dc   = ~lock;
  assign mio  = ~lock;
  assign wr   = ~lock;
  assign addr = '0;
  assign be_n = in_c1 ? BE_FIRST : (in_c2 ? BE_SECOND : '1);

endmodule

// File: rtl/intack_seq_chk.sv
module intack_seq_chk #(
  parameter int ADDR_W = 29,
  parameter int BE_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rdy,
  input logic              ads,
  input logic              lock,
  input logic              dc,
  input logic              mio,
  input logic              wr,
  input logic [BE_W-1:0]   be_n,
  input logic [ADDR_W-1:0] addr,
  input logic              vec_vld
);
  localparam logic [BE_W-1:0] BE_FIRST  = ~(BE_W'(1) << 4);
  localparam logic [BE_W-1:0] BE_SECOND = ~(BE_W'(1));

  AST_STRB_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n) ads |=> !ads); // R3
  AST_CTRL_LOW: assert property (@(posedge clk) disable iff (!rst_n) lock |-> (!dc && !mio && !wr && addr == '0)); // R4
  AST_BE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n) ads |-> (be_n == BE_FIRST || be_n == BE_SECOND)); // R5
  AST_LOCK_COVERS_STRB: assert property (@(posedge clk) disable iff (!rst_n) ads |-> lock); // R6
  AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(lock) |-> (ads && be_n == BE_FIRST)); // R6
  AST_LOCK_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(lock) |-> ($past(rdy) && $past(be_n) == BE_SECOND)); // R6
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n) vec_vld |=> !vec_vld); // R7
  AST_VLD_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n) vec_vld |-> $fell(lock)); // R7
  AST_LOCK_GAP: assert property (@(posedge clk) disable iff (!rst_n) $fell(lock) |=> !lock); // R8
endmodule

bind intack_seq intack_seq_chk #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy(rdy), .ads(ads), .lock(lock), .dc(dc),
  .mio(mio), .wr(wr), .be_n(be_n), .addr(addr), .vec_vld(vec_vld)
);

// File: tb/intack_seq_test.sv
module intack_seq_test;
  localparam int ADDR_W = 29;
  localparam int BE_W   = 8;
  localparam int VEC_W  = 8;
  localparam int GAP    = 3;
  localparam int NRUN   = 5;
  // entry: {w1[3:0], w2[3:0], vector[7:0], early_rdy}
  localparam logic [16:0] RUNS [NRUN] = '{
    {4'd0, 4'd0, 8'h00, 1'b0},
    {4'd2, 4'd1, 8'hA5, 1'b0},
    {4'd0, 4'd3, 8'hFF, 1'b1},
    {4'd4, 4'd0, 8'h3C, 1'b1},
    {4'd1, 4'd2, 8'h81, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic irq_in = 1'b0, insn_bdry = 1'b0, rdy = 1'b0;
  logic [VEC_W-1:0] rdata = '0;
  logic ads, lock, dc, mio, wr, vec_vld;
  logic [BE_W-1:0] be_n;
  logic [ADDR_W-1:0] addr;
  logic [VEC_W-1:0] vec;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  intack_seq #(.ADDR_W(ADDR_W), .BE_W(BE_W), .VEC_W(VEC_W), .GAP_CLKS(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .insn_bdry(insn_bdry), .rdy(rdy),
    .rdata(rdata), .ads(ads), .lock(lock), .dc(dc), .mio(mio), .wr(wr),
    .be_n(be_n), .addr(addr), .vec(vec), .vec_vld(vec_vld)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_idle_ctl(input string req);
    chk(dc && mio && wr, req, "idle dc/mio/wr", {dc, mio, wr}, 7);
    chk(be_n == 8'hFF, req, "idle be_n", be_n, 8'hFF);
  endtask

  // Runs a full acknowledge sequence from the strobe of cycle one; call at the negedge where ads is seen.
  task automatic finish_seq(input int w1, input int w2, input logic [7:0] v, input bit early, input logic [7:0] vprev);
    chk(ads && lock, "R6", "lock with first ads", {ads, lock}, 3);
    chk(be_n == 8'hEF, "R5", "first be_n", be_n, 8'hEF);
    chk(!dc && !mio && !wr && addr == '0, "R4", "ctl low cycle 1", {dc, mio, wr}, 0);
    rdy = early;
    rdata = 8'h77;
    for (int k = 0; k <= w1; k++) begin
      @(negedge clk);
      if (k == 0) chk(!ads && be_n == 8'hEF && lock, "R3", "data phase 1 after strobe", ads, 0);
      rdy = (k == w1);
      if (k < w1) begin
        @(negedge clk);
        chk(!ads && be_n == 8'hEF, "R3", "wait state cycle 1", be_n, 8'hEF);
        k++;
        rdy = (k == w1);
        if (k == w1) begin
          @(negedge clk);
          break;
        end
        k--;
        rdy = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    rdy = 1'b0;
    chk(ads && lock && be_n == 8'hFE, "R5", "second strobe be_n", be_n, 8'hFE);
    chk(!dc && !mio && !wr && addr == '0, "R4", "ctl low cycle 2", {dc, mio, wr}, 0);
    chk(vec == vprev, "R7", "first data ignored", vec, vprev);
    for (int k = 0; k < w2; k++) begin
      @(negedge clk);
      chk(!ads && lock && be_n == 8'hFE, "R3", "wait state cycle 2", be_n, 8'hFE);
    end
    @(negedge clk);
    if (w2 == 0) chk(!ads && lock && be_n == 8'hFE, "R3", "data phase 2", be_n, 8'hFE);
    rdy = 1'b1;
    rdata = v;
    @(negedge clk);
    rdy = 1'b0;
    rdata = 8'h00;
    chk(!lock, "R6", "lock low after final ready", lock, 0);
    chk(vec_vld && vec == v, "R7", "vector capture", vec, v);
    chk_idle_ctl("R4");
    @(negedge clk);
    chk(!vec_vld, "R7", "valid is one clock", vec_vld, 0);
  endtask

  task automatic wait_ads(output int n);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      n++;
      if (ads) break;
    end
  endtask

  initial begin
    int n;
    logic [7:0] vprev;
    repeat (3) @(negedge clk);
    chk(!ads && !lock && !vec_vld && vec == 0, "R9", "reset outputs", {ads, lock, vec_vld}, 0);
    chk_idle_ctl("R9");
    rst_n = 1'b1;
    @(negedge clk);
    vprev = 8'h00;

    for (int r = 0; r < NRUN; r++) begin
      irq_in = 1'b1;
      insn_bdry = 1'b1;
      wait_ads(n);
      chk(n == 5, "R1", "strobe latency", n, 5);
      finish_seq(int'(RUNS[r][16:13]), int'(RUNS[r][12:9]), RUNS[r][8:1], RUNS[r][0], vprev);
      vprev = RUNS[r][8:1];
      irq_in = 1'b0;
      insn_bdry = 1'b0;
      repeat (GAP + 6) @(negedge clk);
      chk(!ads && !lock, "R8", "idle after run", lock, 0);
    end

    // R1: single-clock pulse is not a request
    irq_in = 1'b1;
    insn_bdry = 1'b1;
    @(negedge clk);
    irq_in = 1'b0;
    n = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (ads || lock) n++;
    end
    chk(n == 0, "R1", "one-clock pulse ignored", n, 0);
    insn_bdry = 1'b0;

    // R2: wait for boundary, then strobe one cycle after it
    irq_in = 1'b1;
    n = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (ads) n++;
    end
    chk(n == 0, "R2", "no strobe without boundary", n, 0);
    insn_bdry = 1'b1;
    @(negedge clk);
    insn_bdry = 1'b0;
    chk(ads, "R2", "strobe after boundary", ads, 1);
    finish_seq(0, 0, 8'h5A, 1'b0, vprev);
    vprev = 8'h5A;
    irq_in = 1'b0;
    repeat (GAP + 6) @(negedge clk);

    // R2: request withdrawn while waiting
    irq_in = 1'b1;
    repeat (8) @(negedge clk);
    irq_in = 1'b0;
    repeat (4) @(negedge clk);
    insn_bdry = 1'b1;
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (ads) n++;
    end
    chk(n == 0, "R2", "withdrawn request dropped", n, 0);
    insn_bdry = 1'b0;

    // R3: ready while idle ignored
    rdy = 1'b1;
    rdata = 8'h99;
    n = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (vec_vld || lock) n++;
    end
    rdy = 1'b0;
    rdata = 8'h00;
    chk(n == 0 && vec == vprev, "R3", "idle ready ignored", vec, vprev);

    // R8: back-to-back sequences, lock-low window
    irq_in = 1'b1;
    insn_bdry = 1'b1;
    wait_ads(n);
    finish_seq(0, 1, 8'h11, 1'b0, vprev);
    n = 1;
    for (int i = 0; i < 20; i++) begin
      if (ads) break;
      chk(!lock, "R8", "lock low in gap", lock, 0);
      @(negedge clk);
      n++;
    end
    chk(n == GAP + 2, "R8", "lock-low clocks between sequences", n, GAP + 2);
    finish_seq(0, 0, 8'h22, 1'b0, 8'h11);
    irq_in = 1'b0;
    insn_bdry = 1'b0;
    repeat (GAP + 6) @(negedge clk);
    chk(!lock && !ads && vec == 8'h22, "R7", "final vector held", vec, 8'h22);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule